// File: doc/BRIEF.md
# Grouped Interrupt Expander

The expander gathers a large set of peripheral interrupt lines, arranged as twelve groups of sixteen, and presents one request line per group to the processor. A rising edge on any input records a pending flag for that line. A flag turns into a request only when three conditions hold: its line is enabled, its group is open, and the global enable is on. As an example of the wiring, the event interrupt of the first pulse-width modulator sits on group index 2, line 0.

Alongside the request lines, the block presents a vector index for table lookup: the lowest-numbered requesting group, and the lowest pending enabled line within that group. When the processor reports that it has taken the vector, that line's flag is cleared and its group is closed. A closed group stays silent until software writes its bit in the reopen register.

All state is reached through a small write/read port. The 6-bit address is split into a page in bits [5:4] and an index in bits [3:0]:

- Page 0, index 0: control register. Bit 0 is the global enable.
- Page 0, index 1: group-open register. Bit g reads 1 while group g is open; writing 1 to bit g reopens group g.
- Page 1, index g: enable register of group g.
- Page 2, index g: flag register of group g.

Top module: `grp_irq_expander`

## Requirements
- R1: After reset all flags and enables read 0, the control register reads 0, the group-open register (address 0x01) reads 0x0FFF, no `cpu_irq` bit is set and `vec_valid` is low.
- R2: A rising edge on input line l of group g (bit g*16+l of `irq_lines`) sets bit l of the flag register at address 0x20+g, whether or not that line is enabled. A line that stays high does not set its flag again once the flag has been cleared.
- R3: `cpu_irq[g]` is high exactly when bit 0 of address 0x00 is 1, group g is open, and the flag register AND the enable register (address 0x10+g) of group g is nonzero.
- R4: While the global enable is 0, every `cpu_irq` bit and `vec_valid` stay low, and flags keep collecting edges.
- R5: `vec_group` gives the lowest group index with `cpu_irq` set. `vec_line` gives the lowest pending enabled line of that group. `vec_valid` is high whenever any `cpu_irq` bit is high.
- R6: A `vec_taken` pulse while `vec_valid` is high clears the flag at (`vec_group`, `vec_line`) and closes that group: its bit in 0x01 reads 0 and its `cpu_irq` stays low even if other lines of the group are pending.
- R7: Writing 1 to bit g of address 0x01 reopens group g. Bits written as 0 change nothing.
- R8: A write to a flag register ANDs the data into the flags, so 0x0000 clears them all. A rising edge in the same cycle still sets its flag.
- R9: Enable registers read back what was written. Addresses outside the map (page 3, page 0 indices above 1, indices 12 to 15 on pages 1 and 2) read 0, and writes to them change nothing.
- R10: A `vec_taken` pulse while `vec_valid` is low changes no flag and no group-open bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 192 | Peripheral interrupt inputs, group g line l at bit g*16+l |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address: page [5:4], index [3:0] |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` (combinational) |
| cpu_irq | output | 12 | One request line per group |
| vec_valid | output | 1 | A vector is being presented |
| vec_group | output | 4 | Winning group index |
| vec_line | output | 4 | Winning line index within the group |
| vec_taken | input | 1 | Processor has taken the presented vector |

## Verification
The hardest state to reach is a closed group that still holds pending, enabled flags. Reaching it takes an edge, an enable, a take handshake, and then a fresh edge that arrives before the reopen write. The bench builds exactly this sequence for every one of the 192 lines and confirms the request stays low until the reopen bit is written. Per-group sweeps then pulse many lines of one group at once and drain them through repeated take/reopen rounds, checking the lowest-line order. Cross-group rounds check the lowest-group order in the same way.

// File: rtl/gie_pkg.sv
package gie_pkg;
  typedef enum logic [1:0] {
    PG_SYS = 2'd0,
    PG_ENA = 2'd1,
    PG_FLG = 2'd2,
    PG_RSV = 2'd3
  } page_e;

  localparam int          ADDR_W   = 6;
  localparam int          IDX_W    = 4;
  localparam logic [3:0]  IDX_CTRL = 4'd0;
  localparam logic [3:0]  IDX_OPEN = 4'd1;
endpackage

// File: rtl/gie_group.sv
module gie_group #(
  parameter int LINES = 16,
  parameter int LW    = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] lines_i,
  input  logic [LINES-1:0] wdata_i,
  input  logic             en_wr_i,
  input  logic             flag_wr_i,
  input  logic             ack_i,
  input  logic             take_i,
  input  logic             gen_i,
  output logic             req_o,
  output logic [LW-1:0]    line_o,
  output logic [LINES-1:0] flag_o,
  output logic [LINES-1:0] en_o,
  output logic             open_o
);
  logic [LINES-1:0] flag_q, flag_d, en_q, prev_q, rise, pend, take_mask, keep;
  logic             open_q, open_d;

  always_comb begin
    rise = lines_i & ~prev_q;
    pend = flag_q & en_q;
    line_o = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (pend[i]) line_o = LW'(i);
    end
    take_mask = '0;
    if (take_i) take_mask[line_o] = 1'b1;
    keep   = flag_wr_i ? (flag_q & wdata_i) : flag_q;
    flag_d = (keep & ~take_mask) | rise;
    open_d = open_q;
    if (ack_i)  open_d = 1'b1;
    if (take_i) open_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      prev_q <= '0;
      open_q <= 1'b1;
    end else begin
      flag_q <= flag_d;
      prev_q <= lines_i;
      open_q <= open_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= '0;
    else if (en_wr_i) en_q <= wdata_i;
  end

  assign req_o  = gen_i & open_q & (|pend);
  assign flag_o = flag_q;
  assign en_o   = en_q;
  assign open_o = open_q;

  // R2: an edge always lands in the flag register
  assert_edge_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((flag_q & $past(rise)) == $past(rise)));
  // R5: reported line is the lowest pending enabled one
  assert_lowest_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> (pend[line_o] && ((pend & ((LINES'(1) << line_o) - LINES'(1))) == '0)));
  // R6: a take closes the group
  assert_take_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> !open_q);
  // R6: a take clears the taken flag unless a new edge arrives on it
  assert_take_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !rise[line_o]) |=> !flag_q[$past(line_o)]);
  // R7: reopen write opens the group
  assert_ack_reopens_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !take_i) |=> open_q);
endmodule

// File: rtl/gie_arb.sv
module gie_arb #(
  parameter int NG = 12,
  parameter int GW = $clog2(NG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NG-1:0] req_i,
  output logic          valid_o,
  output logic [GW-1:0] grp_o
);
  always_comb begin
    grp_o = '0;
    for (int g = NG - 1; g >= 0; g--) begin
      if (req_i[g]) grp_o = GW'(g);
    end
  end

  assign valid_o = |req_i;

  // R5: winning group requests and no lower group does
  assert_lowest_group_R5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (req_i[grp_o] && ((req_i & ((NG'(1) << grp_o) - NG'(1))) == '0)));
endmodule

// File: rtl/gie_regs.sv
module gie_regs
  import gie_pkg::*;
#(
  parameter int NG    = 12,
  parameter int LINES = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [LINES-1:0]           wdata_i,
  input  logic [NG-1:0][LINES-1:0]   flag_i,
  input  logic [NG-1:0][LINES-1:0]   en_i,
  input  logic [NG-1:0]              open_i,
  output logic                       gen_o,
  output logic [NG-1:0]              en_wr_o,
  output logic [NG-1:0]              flag_wr_o,
  output logic [NG-1:0]              ack_o,
  output logic [LINES-1:0]           rdata_o
);
  page_e            page;
  logic [IDX_W-1:0] idx;
  logic             gen_q, gen_wr;

  assign page = page_e'(addr_i[ADDR_W-1:IDX_W]);
  assign idx  = addr_i[IDX_W-1:0];

  always_comb begin
    gen_wr = we_i && (page == PG_SYS) && (idx == IDX_CTRL);
    for (int g = 0; g < NG; g++) begin
      en_wr_o[g]   = we_i && (page == PG_ENA) && (idx == IDX_W'(g));
      flag_wr_o[g] = we_i && (page == PG_FLG) && (idx == IDX_W'(g));
      ack_o[g]     = we_i && (page == PG_SYS) && (idx == IDX_OPEN) && wdata_i[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gen_q <= 1'b0;
    else if (gen_wr) gen_q <= wdata_i[0];
  end

  assign gen_o = gen_q;

  always_comb begin
    rdata_o = '0;
    unique case (page)
      PG_SYS: begin
        if (idx == IDX_CTRL) rdata_o[0] = gen_q;
        if (idx == IDX_OPEN) rdata_o[NG-1:0] = open_i;
      end
      PG_ENA: begin
        for (int g = 0; g < NG; g++) if (idx == IDX_W'(g)) rdata_o = en_i[g];
      end
      PG_FLG: begin
        for (int g = 0; g < NG; g++) if (idx == IDX_W'(g)) rdata_o = flag_i[g];
      end
      default: rdata_o = '0;
    endcase
  end

  // R9: at most one group register strobed per write
  assert_one_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({en_wr_o, flag_wr_o}));
endmodule

// File: rtl/grp_irq_expander.sv
module grp_irq_expander
  import gie_pkg::*;
#(
  parameter int NG    = 12,
  parameter int LINES = 16,
  parameter int GW    = $clog2(NG),
  parameter int LW    = $clog2(LINES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NG*LINES-1:0] irq_lines,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [LINES-1:0]    reg_wdata,
  output logic [LINES-1:0]    reg_rdata,
  output logic [NG-1:0]       cpu_irq,
  output logic                vec_valid,
  output logic [GW-1:0]       vec_group,
  output logic [LW-1:0]       vec_line,
  input  logic                vec_taken
);
  logic [1:0]                 rst_sync;
  logic                       rst_n_s;
  logic                       gen;
  logic [NG-1:0]              en_wr, flag_wr, ack, take, grp_open;
  logic [NG-1:0][LINES-1:0]   grp_flag, grp_en;
  logic [NG-1:0][LW-1:0]      grp_line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  gie_regs #(.NG(NG), .LINES(LINES)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .we_i(reg_we), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .flag_i(grp_flag), .en_i(grp_en), .open_i(grp_open),
    .gen_o(gen), .en_wr_o(en_wr), .flag_wr_o(flag_wr), .ack_o(ack),
    .rdata_o(reg_rdata)
  );

  always_comb begin
    for (int g = 0; g < NG; g++) begin
      take[g] = vec_taken && vec_valid && (vec_group == GW'(g));
    end
  end

  for (genvar g = 0; g < NG; g++) begin : g_grp
    gie_group #(.LINES(LINES)) u_grp (
      .clk(clk), .rst_n(rst_n_s),
      .lines_i(irq_lines[g*LINES +: LINES]), .wdata_i(reg_wdata),
      .en_wr_i(en_wr[g]), .flag_wr_i(flag_wr[g]), .ack_i(ack[g]),
      .take_i(take[g]), .gen_i(gen),
      .req_o(cpu_irq[g]), .line_o(grp_line[g]), .flag_o(grp_flag[g]),
      .en_o(grp_en[g]), .open_o(grp_open[g])
    );
  end

  gie_arb #(.NG(NG)) u_arb (
    .clk(clk), .rst_n(rst_n_s), .req_i(cpu_irq),
    .valid_o(vec_valid), .grp_o(vec_group)
  );

  assign vec_line = grp_line[vec_group];

  // R4: global enable off silences every output
  assert_gate_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    !gen |-> (cpu_irq == '0 && !vec_valid));
  // R3: a closed group never requests
  assert_closed_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    ((cpu_irq & ~grp_open) == '0));
  // R10: a take with nothing presented leaves group state alone
  assert_idle_take_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (vec_taken && !vec_valid && !reg_we) |=> (grp_open == $past(grp_open)));
endmodule

// File: tb/grp_irq_expander_bench.sv
module grp_irq_expander_bench;
  localparam int NG = 12;
  localparam int L  = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NG*L-1:0] irq_lines = '0;
  logic            reg_we = 1'b0;
  logic [5:0]      reg_addr = '0;
  logic [15:0]     reg_wdata = '0;
  logic [15:0]     reg_rdata;
  logic [NG-1:0]   cpu_irq;
  logic            vec_valid;
  logic [3:0]      vec_group;
  logic [3:0]      vec_line;
  logic            vec_taken = 1'b0;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  grp_irq_expander u_grp_irq_expander (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_irq(cpu_irq), .vec_valid(vec_valid), .vec_group(vec_group),
    .vec_line(vec_line), .vec_taken(vec_taken)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic take();
    vec_taken = 1'b1;
    tick();
    vec_taken = 1'b0;
  endtask

  task automatic pulse_grp(input int g, input logic [15:0] pat);
    irq_lines[g*L +: L] = pat;
    tick();
    irq_lines[g*L +: L] = '0;
  endtask

  function automatic int lowest(input logic [31:0] m);
    for (int i = 0; i < 32; i++) if (m[i]) return i;
    return 0;
  endfunction

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) tick();

    // R1: reset state
    check("R1 cpu_irq", 32'(cpu_irq), 0);
    check("R1 vec_valid", 32'(vec_valid), 0);
    rd(6'h00, d); check("R1 ctrl", 32'(d), 0);
    rd(6'h01, d); check("R1 open", 32'(d), 32'h0FFF);
    for (int g = 0; g < NG; g++) begin
      rd(6'(8'h10 + g), d); check("R1 enable", 32'(d), 0);
      rd(6'(8'h20 + g), d); check("R1 flag", 32'(d), 0);
    end

    // R9: unmapped addresses
    wr(6'h1C, 16'hFFFF); wr(6'h2D, 16'hFFFF); wr(6'h35, 16'hFFFF); wr(6'h02, 16'hFFFF);
    rd(6'h1C, d); check("R9 unmapped enable idx", 32'(d), 0);
    rd(6'h2D, d); check("R9 unmapped flag idx", 32'(d), 0);
    rd(6'h35, d); check("R9 page3", 32'(d), 0);
    rd(6'h02, d); check("R9 sys idx2", 32'(d), 0);
    rd(6'h00, d); check("R9 ctrl untouched", 32'(d), 0);
    for (int g = 0; g < NG; g++) begin
      rd(6'(8'h10 + g), d); check("R9 enables untouched", 32'(d), 0);
    end
    wr(6'h1B, 16'hA55A);
    rd(6'h1B, d); check("R9 enable readback", 32'(d), 32'hA55A);
    wr(6'h1B, 16'h0000);

    wr(6'h00, 16'h0001);

    // Full sweep of every line: R2 R3 R5 R6 R7
    for (int g = 0; g < NG; g++) begin
      for (int l = 0; l < L; l++) begin
        pulse_grp(g, 16'(1 << l));
        rd(6'(8'h20 + g), d); check("R2 flag set while disabled", 32'(d), 32'(1 << l));
        check("R3 no request while disabled", 32'(cpu_irq), 0);
        wr(6'(8'h10 + g), 16'(1 << l));
        check("R3 request", 32'(cpu_irq), 32'(1 << g));
        check("R5 valid", 32'(vec_valid), 1);
        check("R5 group", 32'(vec_group), 32'(g));
        check("R5 line", 32'(vec_line), 32'(l));
        take();
        check("R6 request drops", 32'(cpu_irq), 0);
        rd(6'(8'h20 + g), d); check("R6 flag cleared", 32'(d), 0);
        rd(6'h01, d); check("R6 group closed", 32'(d), 32'h0FFF & ~(32'(1) << g));
        pulse_grp(g, 16'(1 << l));
        check("R6 closed group silent", 32'(cpu_irq), 0);
        wr(6'h01, 16'h0000);
        check("R7 zero write no effect", 32'(cpu_irq), 0);
        wr(6'h01, 16'(1 << g));
        check("R7 reopened", 32'(cpu_irq), 32'(1 << g));
        take();
        wr(6'h01, 16'(1 << g));
        wr(6'(8'h10 + g), 16'h0000);
      end
    end

    // Priority sweep within a group: R5 R6
    for (int k = 0; k < 36; k++) begin
      int g;
      logic [15:0] f, e, m, rem;
      g = k % NG;
      f = 16'((k * 40503 + 4660) ^ (k << 5));
      e = ~16'(k * 15133);
      wr(6'(8'h10 + g), e);
      pulse_grp(g, f);
      rd(6'(8'h20 + g), d); check("R2 multi-edge flags", 32'(d), 32'(f));
      m = f & e;
      rem = f;
      while (m != 0) begin
        int lo;
        lo = lowest(32'(m));
        check("R5 lowest line", 32'(vec_line), 32'(lo));
        check("R3 group request", 32'(cpu_irq), 32'(1 << g));
        take();
        rem[lo] = 1'b0;
        m[lo] = 1'b0;
        rd(6'(8'h20 + g), d); check("R6 only taken flag cleared", 32'(d), 32'(rem));
        check("R6 closed with pending", 32'(cpu_irq), 0);
        wr(6'h01, 16'(1 << g));
      end
      check("R3 drained", 32'(cpu_irq), 0);
      rd(6'(8'h20 + g), d); check("R2 disabled flags stay", 32'(d), 32'(f & ~e));
      wr(6'(8'h20 + g), 16'h0000);
      rd(6'(8'h20 + g), d); check("R8 clear all", 32'(d), 0);
      wr(6'(8'h10 + g), 16'h0000);
    end

    // Cross-group priority: R5
    for (int g = 0; g < NG; g++) wr(6'(8'h10 + g), 16'hFFFF);
    for (int k = 0; k < 30; k++) begin
      logic [11:0] gm;
      gm = 12'((k * 2654) ^ (k << 7) ^ 12'h5A3);
      for (int g = 0; g < NG; g++)
        if (gm[g]) irq_lines[g*L + ((g + k) % L)] = 1'b1;
      tick();
      irq_lines = '0;
      check("R5 all groups request", 32'(cpu_irq), 32'(gm));
      while (gm != 0) begin
        int lg;
        lg = lowest(32'(gm));
        check("R5 lowest group", 32'(vec_group), 32'(lg));
        check("R5 line in group", 32'(vec_line), 32'((lg + k) % L));
        take();
        gm[lg] = 1'b0;
        wr(6'h01, 16'(1 << lg));
      end
      check("R5 valid low when drained", 32'(vec_valid), 0);
    end
    for (int g = 0; g < NG; g++) wr(6'(8'h10 + g), 16'h0000);

    // R4 and R10
    wr(6'h14, 16'h0100);
    wr(6'h00, 16'h0000);
    pulse_grp(4, 16'h0100);
    check("R4 no request", 32'(cpu_irq), 0);
    check("R4 no vector", 32'(vec_valid), 0);
    rd(6'h24, d); check("R4 flag collected", 32'(d), 32'h0100);
    take();
    rd(6'h24, d); check("R10 flag kept", 32'(d), 32'h0100);
    rd(6'h01, d); check("R10 groups open", 32'(d), 32'h0FFF);
    wr(6'h00, 16'h0001);
    check("R4 request after enable", 32'(cpu_irq), 32'h0010);
    check("R4 vector line", 32'(vec_line), 8);
    wr(6'h24, 16'h0000);
    wr(6'h14, 16'h0000);

    // R8: AND-write and same-cycle edge
    pulse_grp(5, 16'hF0F0);
    wr(6'h25, 16'hFF00);
    rd(6'h25, d); check("R8 and-write", 32'(d), 32'hF000);
    irq_lines[5*L + 3] = 1'b1;
    wr(6'h25, 16'h0000);
    irq_lines = '0;
    rd(6'h25, d); check("R8 edge wins over clear", 32'(d), 32'h0008);
    wr(6'h25, 16'h0000);

    // R2: held level does not re-set
    irq_lines[7*L + 9] = 1'b1;
    tick();
    rd(6'h27, d); check("R2 held edge", 32'(d), 32'h0200);
    wr(6'h27, 16'h0000);
    repeat (3) tick();
    rd(6'h27, d); check("R2 held level no re-set", 32'(d), 0);
    irq_lines = '0;
    tick();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule